// File: doc/BRIEF.md
# Touch Gesture Navigation Controller

This block sits between a touch-panel decoder and a photo viewer. The decoder presents a report made of the first touch point's coordinates, a touch count and a gesture code, and it raises a ready strobe when the report is valid. The block passes the strobe through a two-stage synchroniser and finds its rising edge. On that edge it captures the report, works out what the gesture asks for, and updates the viewer's navigation state.

The viewer keeps several equal-sized frames stacked vertically in one image buffer. A horizontal swipe moves to the neighbouring frame, and the frame index wraps at both ends. The block presents the first pixel word address of the selected frame, so a memory reader can fetch it directly. A two-finger pinch moves a zoom level up or down between fixed limits. A report whose code is not a recognised gesture counts as a plain touch. For such a report the block forwards the first point's position together with a single-cycle valid pulse.

Top module: `gesture_nav`

## Requirements
- R1: While reset is held and after it is released, photo_idx is 0, rd_base is 0, zoom_lvl is 1, touch_valid is 0 and touch_x/touch_y are 0.
- R2: A report is acted on only once for each rising edge of rdy_in. Its effect appears on the outputs after the fourth rising clock edge that follows the change of rdy_in. Keeping rdy_in high or letting it fall causes no further action.
- R3: Gesture code 0x14 with touch count 1 or 2 advances photo_idx by one, and 2 advances to 0.
- R4: Gesture code 0x1C with touch count 1 or 2 steps photo_idx back by one, and 0 steps back to 2.
- R5: rd_base always equals photo_idx × 384000 (800 × 480 words per frame) and changes in the same cycle as photo_idx.
- R6: Gesture code 0x48 raises zoom_lvl by one, holding at 4.
- R7: Gesture code 0x49 lowers zoom_lvl by one, holding at 1.
- R8: A code that is not a defined gesture, with touch count 1 or 2, loads touch_x/touch_y from pt_x/pt_y and drives touch_valid high for exactly one cycle. Between such reports touch_x/touch_y hold their value.
- R9: The other defined codes change neither photo_idx nor zoom_lvl and give no touch_valid pulse: 0x10–0x1E even (except 0x14 and 0x1C), 0x20, 0x22, 0x28, 0x29, 0x30–0x3E even, and 0x40.
- R10: A report with touch count 0 or 3 causes no change to any output, whatever its gesture code.
- R11: Between report effects, photo_idx, zoom_lvl and touch_x/touch_y hold steady, and touch_valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rdy_in | input | 1 | Report-ready strobe, asynchronous to clk |
| pt_x | input | 10 | X coordinate of the first touch point |
| pt_y | input | 9 | Y coordinate of the first touch point |
| touch_cnt | input | 2 | Number of touch points in the report |
| gesture | input | 8 | Gesture code |
| photo_idx | output | 2 | Selected frame index |
| rd_base | output | 21 | First word address of the selected frame |
| zoom_lvl | output | 3 | Zoom level, 1 to 4 |
| touch_valid | output | 1 | One-cycle pulse when a plain touch is reported |
| touch_x | output | 10 | X position of the last plain touch |
| touch_y | output | 9 | Y position of the last plain touch |

## Verification
Every result is due after the fourth rising clock edge that follows a rise of rdy_in: two synchroniser stages, one edge-capture register and one state register. The bench drives the report on a falling edge. It samples once just before that fourth edge to confirm nothing has moved yet, once just after it to check the new state, and once more a cycle later to confirm the touch pulse has ended. A model in the bench tracks the expected frame index, zoom level and touch position through a sweep of every gesture code. It also checks the wrap and saturation boundaries and the report counts that must be ignored.

// File: rtl/gesture_nav_pkg.sv
package gesture_nav_pkg;

    localparam int X_W    = 10;
    localparam int Y_W    = 9;
    localparam int CNT_W  = 2;
    localparam int CODE_W = 8;

    localparam logic [CODE_W-1:0] CODE_NEXT  = 8'h14;
    localparam logic [CODE_W-1:0] CODE_PREV  = 8'h1C;
    localparam logic [CODE_W-1:0] CODE_ZIN   = 8'h48;
    localparam logic [CODE_W-1:0] CODE_ZOUT  = 8'h49;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_TOUCH,
        ACT_PREV,
        ACT_NEXT,
        ACT_ZIN,
        ACT_ZOUT,
        ACT_KEEP
    } act_e;

    typedef struct packed {
        logic [X_W-1:0]    x;
        logic [Y_W-1:0]    y;
        logic [CNT_W-1:0]  cnt;
        logic [CODE_W-1:0] code;
    } report_t;

    // Direction codes: even values in the 0x10 or 0x30 row
    function automatic logic is_swipe(input logic [CODE_W-1:0] c);
        return ((c[7:4] == 4'h1) || (c[7:4] == 4'h3)) && !c[0];
    endfunction

    function automatic logic is_defined(input logic [CODE_W-1:0] c);
        logic misc;
        misc = (c == 8'h20) || (c == 8'h22) || (c == 8'h28) || (c == 8'h29) ||
               (c == 8'h40) || (c == CODE_ZIN) || (c == CODE_ZOUT);
        return is_swipe(c) || misc;
    endfunction

    function automatic act_e classify(input report_t r);
        act_e a;
        if (r.cnt == 2'd0 || r.cnt == 2'd3) begin
            a = ACT_NONE;
        end else if (r.code == CODE_NEXT) begin
            a = ACT_NEXT;
        end else if (r.code == CODE_PREV) begin
            a = ACT_PREV;
        end else if (r.code == CODE_ZIN) begin
            a = ACT_ZIN;
        end else if (r.code == CODE_ZOUT) begin
            a = ACT_ZOUT;
        end else if (is_defined(r.code)) begin
            a = ACT_KEEP;
        end else begin
            a = ACT_TOUCH;
        end
        return a;
    endfunction

endpackage

// File: rtl/gn_edge_sync.sv
module gn_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    // bits [STAGES-1:0] synchronise, bit STAGES holds the previous synced value
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], async_in};
        end
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/gn_capture.sv
module gn_capture
    import gesture_nav_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    take,
    input  report_t rep_in,
    output logic    cap_vld,
    output report_t cap_rep,
    output act_e    cap_act
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_vld <= 1'b0;
            cap_rep <= '0;
        end else begin
            cap_vld <= take;
            if (take) begin
                cap_rep <= rep_in;
            end
        end
    end

    assign cap_act = classify(cap_rep);
endmodule

// File: rtl/gn_nav_state.sv
module gn_nav_state
    import gesture_nav_pkg::*;
#(
    parameter int NUM_FRAMES  = 3,
    parameter int FRAME_WORDS = 384000,
    parameter int ADDR_W      = 21,
    parameter int IDX_W       = 2,
    parameter int ZOOM_W      = 3,
    parameter int ZOOM_MIN    = 1,
    parameter int ZOOM_MAX    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vld,
    input  act_e              act,
    input  logic [X_W-1:0]    in_x,
    input  logic [Y_W-1:0]    in_y,
    output logic [IDX_W-1:0]  photo_idx,
    output logic [ADDR_W-1:0] rd_base,
    output logic [ZOOM_W-1:0] zoom_lvl,
    output logic              touch_valid,
    output logic [X_W-1:0]    touch_x,
    output logic [Y_W-1:0]    touch_y
);
    localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(NUM_FRAMES - 1);
    localparam logic [ZOOM_W-1:0] Z_LO     = ZOOM_W'(ZOOM_MIN);
    localparam logic [ZOOM_W-1:0] Z_HI     = ZOOM_W'(ZOOM_MAX);

    logic [IDX_W-1:0]  idx_nx;
    logic [ZOOM_W-1:0] zoom_nx;

    always_comb begin
        idx_nx  = photo_idx;
        zoom_nx = zoom_lvl;
        if (vld) begin
            unique case (act)
                ACT_NEXT: idx_nx  = (photo_idx == IDX_LAST) ? '0 : photo_idx + 1'b1;
                ACT_PREV: idx_nx  = (photo_idx == '0) ? IDX_LAST : photo_idx - 1'b1;
                ACT_ZIN:  zoom_nx = (zoom_lvl >= Z_HI) ? Z_HI : zoom_lvl + 1'b1;
                ACT_ZOUT: zoom_nx = (zoom_lvl <= Z_LO) ? Z_LO : zoom_lvl - 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            photo_idx   <= '0;
            rd_base     <= '0;
            zoom_lvl    <= Z_LO;
            touch_valid <= 1'b0;
            touch_x     <= '0;
            touch_y     <= '0;
        end else begin
            photo_idx   <= idx_nx;
            rd_base     <= ADDR_W'(FRAME_WORDS) * ADDR_W'(idx_nx);
            zoom_lvl    <= zoom_nx;
            touch_valid <= vld && (act == ACT_TOUCH);
            if (vld && act == ACT_TOUCH) begin
                touch_x <= in_x;
                touch_y <= in_y;
            end
        end
    end
endmodule

// File: rtl/gesture_nav.sv
module gesture_nav
    import gesture_nav_pkg::*;
#(
    parameter  int SYNC_STAGES = 2,
    parameter  int NUM_FRAMES  = 3,
    parameter  int FRAME_COLS  = 800,
    parameter  int FRAME_ROWS  = 480,
    parameter  int ZOOM_W      = 3,
    parameter  int ZOOM_MIN    = 1,
    parameter  int ZOOM_MAX    = 4,
    localparam int FRAME_WORDS = FRAME_COLS * FRAME_ROWS,
    localparam int ADDR_W      = $clog2(NUM_FRAMES * FRAME_WORDS),
    localparam int IDX_W       = $clog2(NUM_FRAMES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rdy_in,
    input  logic [X_W-1:0]    pt_x,
    input  logic [Y_W-1:0]    pt_y,
    input  logic [CNT_W-1:0]  touch_cnt,
    input  logic [CODE_W-1:0] gesture,
    output logic [IDX_W-1:0]  photo_idx,
    output logic [ADDR_W-1:0] rd_base,
    output logic [ZOOM_W-1:0] zoom_lvl,
    output logic              touch_valid,
    output logic [X_W-1:0]    touch_x,
    output logic [Y_W-1:0]    touch_y
);
    logic    rdy_rise;
    logic    cap_vld;
    report_t rep_in;
    report_t cap_rep;
    act_e    cap_act;

    assign rep_in = '{x: pt_x, y: pt_y, cnt: touch_cnt, code: gesture};

    gn_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (rdy_in),
        .rise     (rdy_rise)
    );

    gn_capture u_cap (
        .clk     (clk),
        .rst     (rst),
        .take    (rdy_rise),
        .rep_in  (rep_in),
        .cap_vld (cap_vld),
        .cap_rep (cap_rep),
        .cap_act (cap_act)
    );

    gn_nav_state #(
        .NUM_FRAMES  (NUM_FRAMES),
        .FRAME_WORDS (FRAME_WORDS),
        .ADDR_W      (ADDR_W),
        .IDX_W       (IDX_W),
        .ZOOM_W      (ZOOM_W),
        .ZOOM_MIN    (ZOOM_MIN),
        .ZOOM_MAX    (ZOOM_MAX)
    ) u_state (
        .clk         (clk),
        .rst         (rst),
        .vld         (cap_vld),
        .act         (cap_act),
        .in_x        (cap_rep.x),
        .in_y        (cap_rep.y),
        .photo_idx   (photo_idx),
        .rd_base     (rd_base),
        .zoom_lvl    (zoom_lvl),
        .touch_valid (touch_valid),
        .touch_x     (touch_x),
        .touch_y     (touch_y)
    );
endmodule

// File: rtl/gn_checker.sv
module gn_checker #(
    parameter int NUM_FRAMES  = 3,
    parameter int FRAME_WORDS = 384000,
    parameter int ADDR_W      = 21,
    parameter int IDX_W       = 2,
    parameter int ZOOM_W      = 3,
    parameter int ZOOM_MIN    = 1,
    parameter int ZOOM_MAX    = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cap_vld,
    input logic [IDX_W-1:0]  photo_idx,
    input logic [ADDR_W-1:0] rd_base,
    input logic [ZOOM_W-1:0] zoom_lvl,
    input logic              touch_valid,
    input logic [9:0]        touch_x,
    input logic [8:0]        touch_y
);
    // R5
    base_match_chk: assert property (@(posedge clk) disable iff (rst)
        32'(rd_base) == FRAME_WORDS * 32'(photo_idx));

    // R3
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        32'(photo_idx) < NUM_FRAMES);

    // R6
    zoom_range_chk: assert property (@(posedge clk) disable iff (rst)
        32'(zoom_lvl) >= ZOOM_MIN && 32'(zoom_lvl) <= ZOOM_MAX);

    // R7
    zoom_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(zoom_lvl) |->
            (zoom_lvl == $past(zoom_lvl) + 1'b1) || (zoom_lvl + 1'b1 == $past(zoom_lvl)));

    // R8
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        touch_valid |=> !touch_valid);

    // R11
    hold_state_chk: assert property (@(posedge clk) disable iff (rst)
        !cap_vld |=> $stable(photo_idx) && $stable(zoom_lvl) && !touch_valid
                     && $stable(touch_x) && $stable(touch_y));
endmodule

bind gesture_nav gn_checker #(
    .NUM_FRAMES  (NUM_FRAMES),
    .FRAME_WORDS (FRAME_WORDS),
    .ADDR_W      (ADDR_W),
    .IDX_W       (IDX_W),
    .ZOOM_W      (ZOOM_W),
    .ZOOM_MIN    (ZOOM_MIN),
    .ZOOM_MAX    (ZOOM_MAX)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cap_vld     (cap_vld),
    .photo_idx   (photo_idx),
    .rd_base     (rd_base),
    .zoom_lvl    (zoom_lvl),
    .touch_valid (touch_valid),
    .touch_x     (touch_x),
    .touch_y     (touch_y)
);

// File: tb/gesture_nav_test.sv
module gesture_nav_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rdy = 1'b0;
    logic [9:0]  pt_x = '0;
    logic [8:0]  pt_y = '0;
    logic [1:0]  cnt = '0;
    logic [7:0]  gest = '0;
    logic [1:0]  photo_idx;
    logic [20:0] rd_base;
    logic [2:0]  zoom_lvl;
    logic        touch_valid;
    logic [9:0]  touch_x;
    logic [8:0]  touch_y;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    int m_idx = 0, m_zoom = 1, m_tx = 0, m_ty = 0, m_tv = 0;

    always #4 clk = ~clk;

    gesture_nav uut (
        .clk(clk), .rst(rst), .rdy_in(rdy), .pt_x(pt_x), .pt_y(pt_y),
        .touch_cnt(cnt), .gesture(gest), .photo_idx(photo_idx), .rd_base(rd_base),
        .zoom_lvl(zoom_lvl), .touch_valid(touch_valid), .touch_x(touch_x), .touch_y(touch_y)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "photo_idx", int'(photo_idx), m_idx);
        chk("R5", "rd_base", int'(rd_base), m_idx * 384000);
        chk(req, "zoom_lvl", int'(zoom_lvl), m_zoom);
        chk(req, "touch_valid", int'(touch_valid), m_tv);
        chk(req, "touch_x", int'(touch_x), m_tx);
        chk(req, "touch_y", int'(touch_y), m_ty);
    endtask

    function automatic bit defined_code(input int g);
        bit swipe;
        swipe = ((g >= 'h10 && g <= 'h1E) || (g >= 'h30 && g <= 'h3E)) && (g % 2 == 0);
        return swipe || g == 'h20 || g == 'h22 || g == 'h28 || g == 'h29 ||
               g == 'h40 || g == 'h48 || g == 'h49;
    endfunction

    // Bench model of one report; returns the requirement tag it exercises
    function automatic string apply_model(input int x, input int y, input int c, input int g);
        m_tv = 0;
        if (c == 0 || c == 3) return "R10";
        if (g == 'h14) begin m_idx = (m_idx + 1) % 3; return "R3"; end
        if (g == 'h1C) begin m_idx = (m_idx + 2) % 3; return "R4"; end
        if (g == 'h48) begin if (m_zoom < 4) m_zoom++; return "R6"; end
        if (g == 'h49) begin if (m_zoom > 1) m_zoom--; return "R7"; end
        if (defined_code(g)) return "R9";
        m_tx = x; m_ty = y; m_tv = 1;
        return "R8";
    endfunction

    task automatic send(input int x, input int y, input int c, input int g);
        string tag;
        @(negedge clk);
        pt_x = 10'(x); pt_y = 9'(y); cnt = 2'(c); gest = 8'(g); rdy = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2: nothing yet before the fourth edge
        m_tv = 0;
        chk_all("R2");
        tag = apply_model(x, y, c, g);
        @(posedge clk); @(negedge clk);
        chk_all(tag);
        @(posedge clk); @(negedge clk);
        m_tv = 0;
        chk("R8", "touch_valid end", int'(touch_valid), 0);
        rdy = 1'b0;
        repeat (3) @(negedge clk);
        // R11: state holds between reports
        chk_all("R11");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_all("R1");
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk_all("R1");

        // R4 wrap from 0, R3 wrap from 2
        send(1, 1, 1, 'h1C);
        send(1, 1, 2, 'h14);
        for (int i = 0; i < 4; i++) send(2, 2, 1, 'h14);
        for (int i = 0; i < 4; i++) send(2, 2, 2, 'h1C);

        // R6 / R7 saturation
        for (int i = 0; i < 5; i++) send(3, 3, 2, 'h48);
        for (int i = 0; i < 5; i++) send(3, 3, 2, 'h49);

        // R10: counts 0 and 3 ignored for action and plain codes
        send(100, 50, 0, 'h14);
        send(100, 50, 3, 'h48);
        send(100, 50, 0, 'h05);
        send(100, 50, 3, 'hFF);

        // R2: held ready and falling edge give no second action
        @(negedge clk);
        pt_x = 10'd7; pt_y = 9'd7; cnt = 2'd1; gest = 8'h14; rdy = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        m_idx = (m_idx + 1) % 3;
        chk("R2", "idx after edge", int'(photo_idx), m_idx);
        repeat (8) @(negedge clk);
        chk("R2", "idx while held", int'(photo_idx), m_idx);
        rdy = 1'b0;
        repeat (8) @(negedge clk);
        chk("R2", "idx after fall", int'(photo_idx), m_idx);
        chk("R2", "zoom after fall", int'(zoom_lvl), m_zoom);

        // Sweep of every code with counts 1 and 2
        for (int g = 0; g < 256; g++) begin
            send((g * 37) % 1024, (g * 11 + 5) % 512, (g % 2) + 1, g);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule